// File: doc/BRIEF.md
# Temperature Alarm Event Controller

This block watches a stream of temperature samples and raises an alarm event when a sample leaves a programmed window. Each sample is a signed two's-complement code with 0.125 °C per LSB, 11 bits wide by default, which covers −40 °C to +125 °C. A sample is presented with a one-cycle strobe, roughly ten times per second. The block latches the sample into a readable temperature register. It then compares the sample against three programmable limits: a lower alarm, an upper alarm and a critical trip point. The result is three status flags and one event output. The event output drives an open-drain pin, so it is modelled as a pull-low enable.

A simple write port loads the three limits and a configuration word. The configuration word selects the following:
- the hysteresis step applied when a flag releases;
- event enable;
- output polarity;
- level-comparator or latched-interrupt behaviour;
- critical-only alarming;
- a write-one clear of the latched status;
- a lock bit that freezes the limits and the configuration until reset.

Top module: `temp_alarm_ctl`

## Requirements
- R1: After a synchronous reset, all limits, the configuration (including the lock bit), `temp_q`, the three flags, `evt_status` and `evt_pull` are zero.
- R2: On a cycle with `samp_vld` high, `temp_q` takes `samp_code` at the next edge. The three flags change only on an edge where `samp_vld` is high.
- R3: `flag_hi` sets when a sample is greater than the upper limit. It clears when a sample is less than the upper limit minus the hysteresis. Otherwise it holds. Comparisons are signed.
- R4: `flag_lo` sets when a sample is less than the lower limit. It clears when a sample is greater than the lower limit plus the hysteresis. Otherwise it holds.
- R5: `flag_crit` sets when a sample is greater than the critical limit. It clears when a sample is less than the critical limit minus the hysteresis. Otherwise it holds.
- R6: Configuration bits [2:0] select the hysteresis in LSB counts: codes 0 and 1 give 0, code 2 gives 12 (1.5 °C), code 3 gives 24 (3 °C) and code 4 gives 48 (6 °C). Codes 5 to 7 give 0.
- R7: In comparator mode (configuration bit 5 = 0), `evt_status` follows the selected condition one cycle after the flags. The selected condition is the OR of the three flags.
- R8: In interrupt mode (bit 5 = 1), `evt_status` sets one cycle after the selected condition rises. It stays set until a configuration write with bit 7 = 1 clears it. Setting wins over a clear in the same cycle.
- R9: A clear write has no effect while `flag_crit` is high, and it has no effect in comparator mode.
- R10: With bit 6 = 1 (critical-only), the selected condition is `flag_crit` alone.
- R11: `evt_pull` is registered one cycle after `evt_status` and the configuration. It is 0 when bit 3 (enable) is 0. When enabled, it equals `evt_status` if bit 4 = 0 (active-low pin) and the inverse of `evt_status` if bit 4 = 1 (active-high pin).
- R12: Once bit 8 (lock) is written as 1, all later writes to the limits and to configuration bits are ignored until reset. Clear writes still act.
- R13: `wr_sel` selects the target of a write: 0 is the lower limit, 1 the upper limit, 2 the critical limit and 3 the configuration. Limits take `wr_data[TW-1:0]` as a two's-complement code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| samp_vld | input | 1 | New temperature sample strobe |
| samp_code | input | TW | Signed temperature code, 0.125 °C/LSB |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: lower, upper, critical, configuration |
| wr_data | input | DW | Write data |
| temp_q | output | TW | Last latched sample |
| flag_lo | output | 1 | Below lower limit |
| flag_hi | output | 1 | Above upper limit |
| flag_crit | output | 1 | Above critical limit |
| evt_status | output | 1 | Event status |
| evt_pull | output | 1 | Pull-low enable for the open-drain event pin |

## Verification
Each flag is driven through sample sequences that climb past its limit and then step back down. Samples land just inside and just outside the release point for every hysteresis code, so a hysteresis of the wrong size or on the wrong side of the limit shows up. Negative limits and negative samples separate signed comparison from unsigned. Interrupt and comparator runs use the same temperature path: a return to normal temperature followed by a clear tells a latched status apart from a level status, and a clear issued above the critical point checks that critical events cannot be dismissed. Random limits, samples and configuration words are then checked against a behavioural model on every cycle, and a locked run shows that writes change nothing except the clear.

// File: rtl/temp_alarm_pkg.sv
package temp_alarm_pkg;

  typedef enum logic [1:0] {
    SEL_LOWER = 2'd0,
    SEL_UPPER = 2'd1,
    SEL_CRIT  = 2'd2,
    SEL_CFG   = 2'd3
  } reg_sel_e;

  localparam int NTRIP    = 3;
  localparam int T_LO     = 0;
  localparam int T_UP     = 1;
  localparam int T_CR     = 2;

  localparam int CB_HYST  = 0;
  localparam int CB_EN    = 3;
  localparam int CB_AHIGH = 4;
  localparam int CB_IRQ   = 5;
  localparam int CB_CONLY = 6;
  localparam int CB_CLR   = 7;
  localparam int CB_LOCK  = 8;
  localparam int CFG_BITS = 9;

  typedef struct packed {
    logic       lock;
    logic       crit_only;
    logic       irq_mode;
    logic       act_high;
    logic       evt_en;
    logic [2:0] hyst_sel;
  } cfg_t;

  // Release offset in LSB counts; frac = number of fractional bits.
  function automatic int hyst_lsb(input logic [2:0] sel, input int frac);
    case (sel)
      3'd2:    return 3 << (frac - 1);
      3'd3:    return 3 << frac;
      3'd4:    return 3 << (frac + 1);
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/temp_alarm_regs.sv
module temp_alarm_regs
  import temp_alarm_pkg::*;
#(
  parameter int TW = 11,
  parameter int DW = 11
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [1:0]                 wr_sel,
  input  logic [DW-1:0]              wr_data,
  output logic [NTRIP-1:0][TW-1:0]   lim,
  output cfg_t                       cfg,
  output logic                       clr_stb
);

  logic cfg_wr;
  assign cfg_wr  = wr_en && (wr_sel == SEL_CFG);
  // clear acts even when the register file is locked
  assign clr_stb = cfg_wr && wr_data[CB_CLR];

  always_ff @(posedge clk) begin
    if (rst) begin
      lim <= '0;
      cfg <= '0;
    end else if (wr_en && !cfg.lock) begin
      if (cfg_wr) begin
        cfg.hyst_sel  <= wr_data[CB_HYST +: 3];
        cfg.evt_en    <= wr_data[CB_EN];
        cfg.act_high  <= wr_data[CB_AHIGH];
        cfg.irq_mode  <= wr_data[CB_IRQ];
        cfg.crit_only <= wr_data[CB_CONLY];
        cfg.lock      <= wr_data[CB_LOCK];
      end else begin
        for (int i = 0; i < NTRIP; i++) begin
          if (wr_sel == 2'(i)) lim[i] <= wr_data[TW-1:0];
        end
      end
    end
  end

endmodule

// File: rtl/temp_alarm_trip.sv
module temp_alarm_trip #(
  parameter int TW    = 11,
  parameter bit ABOVE = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          smp_vld,
  input  logic [TW-1:0] smp,
  input  logic [TW-1:0] lim,
  input  logic [TW-1:0] hyst,
  output logic          flag
);

  localparam int XW = TW + 2;

  logic signed [XW-1:0] t_x, l_x, h_x, rel_pt;
  logic                 trip, release_ok;

  assign t_x = {{2{smp[TW-1]}}, smp};
  assign l_x = {{2{lim[TW-1]}}, lim};
  assign h_x = {2'b00, hyst};

  generate
    if (ABOVE) begin : g_above
      assign rel_pt     = l_x - h_x;
      assign trip       = t_x > l_x;
      assign release_ok = t_x < rel_pt;
    end else begin : g_below
      assign rel_pt     = l_x + h_x;
      assign trip       = t_x < l_x;
      assign release_ok = t_x > rel_pt;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
    end else if (smp_vld) begin
      if (trip)            flag <= 1'b1;
      else if (release_ok) flag <= 1'b0;
    end
  end

endmodule

// File: rtl/temp_alarm_evt.sv
module temp_alarm_evt #(
  parameter int NT = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NT-1:0] flags,
  input  logic          crit_flag,
  input  logic          crit_only,
  input  logic          irq_mode,
  input  logic          evt_en,
  input  logic          act_high,
  input  logic          clr_stb,
  output logic          status,
  output logic          pull
);

  logic sel_now, sel_d, rise;

  assign sel_now = crit_only ? crit_flag : |flags;
  assign rise    = sel_now & ~sel_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_d  <= 1'b0;
      status <= 1'b0;
      pull   <= 1'b0;
    end else begin
      sel_d <= sel_now;
      pull  <= evt_en & (act_high ? ~status : status);
      if (!irq_mode)                  status <= sel_now;
      else if (rise)                  status <= 1'b1;
      else if (clr_stb && !crit_flag) status <= 1'b0;
    end
  end

endmodule

// File: rtl/temp_alarm_ctl.sv
module temp_alarm_ctl
  import temp_alarm_pkg::*;
#(
  parameter int TW   = 11,
  parameter int FRAC = 3,
  parameter int DW   = (TW > CFG_BITS) ? TW : CFG_BITS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          samp_vld,
  input  logic [TW-1:0] samp_code,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [DW-1:0] wr_data,
  output logic [TW-1:0] temp_q,
  output logic          flag_lo,
  output logic          flag_hi,
  output logic          flag_crit,
  output logic          evt_status,
  output logic          evt_pull
);

  logic [NTRIP-1:0][TW-1:0] lim;
  logic [NTRIP-1:0]         flags;
  logic [TW-1:0]            hyst;
  cfg_t                     cfg;
  logic                     clr_stb;

  // named views used by the bound checker
  logic          cfg_lock, cfg_en, cfg_irq;
  logic [TW-1:0] lim_lo, lim_up, lim_cr;
  assign cfg_lock = cfg.lock;
  assign cfg_en   = cfg.evt_en;
  assign cfg_irq  = cfg.irq_mode;
  assign lim_lo   = lim[T_LO];
  assign lim_up   = lim[T_UP];
  assign lim_cr   = lim[T_CR];

  temp_alarm_regs #(.TW(TW), .DW(DW)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .lim     (lim),
    .cfg     (cfg),
    .clr_stb (clr_stb)
  );

  assign hyst = TW'(hyst_lsb(cfg.hyst_sel, FRAC));

  always_ff @(posedge clk) begin
    if (rst)           temp_q <= '0;
    else if (samp_vld) temp_q <= samp_code;
  end

  generate
    for (genvar g = 0; g < NTRIP; g++) begin : g_trip
      temp_alarm_trip #(.TW(TW), .ABOVE(g != T_LO)) u_trip (
        .clk     (clk),
        .rst     (rst),
        .smp_vld (samp_vld),
        .smp     (samp_code),
        .lim     (lim[g]),
        .hyst    (hyst),
        .flag    (flags[g])
      );
    end
  endgenerate

  assign flag_lo   = flags[T_LO];
  assign flag_hi   = flags[T_UP];
  assign flag_crit = flags[T_CR];

  temp_alarm_evt #(.NT(NTRIP)) u_evt (
    .clk       (clk),
    .rst       (rst),
    .flags     (flags),
    .crit_flag (flags[T_CR]),
    .crit_only (cfg.crit_only),
    .irq_mode  (cfg.irq_mode),
    .evt_en    (cfg.evt_en),
    .act_high  (cfg.act_high),
    .clr_stb   (clr_stb),
    .status    (evt_status),
    .pull      (evt_pull)
  );

endmodule

// File: rtl/temp_alarm_chk.sv
module temp_alarm_chk #(
  parameter int TW = 11
) (
  input logic          clk,
  input logic          rst,
  input logic          samp_vld,
  input logic [TW-1:0] samp_code,
  input logic          wr_en,
  input logic [TW-1:0] temp_q,
  input logic          flag_lo,
  input logic          flag_hi,
  input logic          flag_crit,
  input logic          evt_status,
  input logic          evt_pull,
  input logic          cfg_lock,
  input logic          cfg_en,
  input logic          cfg_irq,
  input logic [TW-1:0] lim_lo,
  input logic [TW-1:0] lim_up,
  input logic [TW-1:0] lim_cr
);

  assert_temp_latch_R2: assert property (@(posedge clk) disable iff (rst)
    samp_vld |=> temp_q == $past(samp_code));

  assert_flags_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !samp_vld |=> $stable({flag_lo, flag_hi, flag_crit}));

  assert_hi_set_R3: assert property (@(posedge clk) disable iff (rst)
    (samp_vld && ($signed(samp_code) > $signed(lim_up))) |=> flag_hi);

  assert_lo_set_R4: assert property (@(posedge clk) disable iff (rst)
    (samp_vld && ($signed(samp_code) < $signed(lim_lo))) |=> flag_lo);

  assert_crit_set_R5: assert property (@(posedge clk) disable iff (rst)
    (samp_vld && ($signed(samp_code) > $signed(lim_cr))) |=> flag_crit);

  assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (cfg_irq && evt_status && !wr_en) |=> evt_status);

  assert_crit_noclear_R9: assert property (@(posedge clk) disable iff (rst)
    (cfg_irq && cfg_lock && flag_crit && evt_status) |=> evt_status);

  assert_disabled_R11: assert property (@(posedge clk) disable iff (rst)
    !cfg_en |=> !evt_pull);

  assert_lock_R12: assert property (@(posedge clk) disable iff (rst)
    cfg_lock |=> (cfg_lock && $stable(lim_lo) && $stable(lim_up) && $stable(lim_cr)));

endmodule

bind temp_alarm_ctl temp_alarm_chk #(.TW(TW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .samp_vld   (samp_vld),
  .samp_code  (samp_code),
  .wr_en      (wr_en),
  .temp_q     (temp_q),
  .flag_lo    (flag_lo),
  .flag_hi    (flag_hi),
  .flag_crit  (flag_crit),
  .evt_status (evt_status),
  .evt_pull   (evt_pull),
  .cfg_lock   (cfg_lock),
  .cfg_en     (cfg_en),
  .cfg_irq    (cfg_irq),
  .lim_lo     (lim_lo),
  .lim_up     (lim_up),
  .lim_cr     (lim_cr)
);

// File: tb/temp_alarm_ctl_tb.sv
module temp_alarm_ctl_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        samp_vld = 1'b0;
  logic [10:0] samp_code = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [10:0] wr_data = '0;
  logic [10:0] temp_q;
  logic        flag_lo, flag_hi, flag_crit, evt_status, evt_pull;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  temp_alarm_ctl u_dut (
    .clk(clk), .rst(rst), .samp_vld(samp_vld), .samp_code(samp_code),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .temp_q(temp_q),
    .flag_lo(flag_lo), .flag_hi(flag_hi), .flag_crit(flag_crit),
    .evt_status(evt_status), .evt_pull(evt_pull)
  );

  // ---------------- behavioural reference model ----------------
  int   m_lo, m_up, m_cr, m_temp, m_h, t;
  logic [8:0] m_cfg;
  logic m_flo, m_fhi, m_fcr, m_sel, m_seld, m_stat, m_pull, clr;

  always @(posedge clk) begin
    if (rst) begin
      m_lo = 0; m_up = 0; m_cr = 0; m_temp = 0; m_cfg = '0;
      m_flo = 0; m_fhi = 0; m_fcr = 0; m_seld = 0; m_stat = 0; m_pull = 0;
    end else begin
      m_pull = m_cfg[3] ? (m_cfg[4] ? !m_stat : m_stat) : 1'b0;
      m_sel  = m_cfg[6] ? m_fcr : (m_flo | m_fhi | m_fcr);
      clr    = wr_en && wr_sel == 2'd3 && wr_data[7];
      if (!m_cfg[5]) m_stat = m_sel;
      else if (m_sel && !m_seld) m_stat = 1;
      else if (clr && !m_fcr) m_stat = 0;
      m_seld = m_sel;
      case (m_cfg[2:0])
        3'd2: m_h = 12;
        3'd3: m_h = 24;
        3'd4: m_h = 48;
        default: m_h = 0;
      endcase
      if (samp_vld) begin
        t = $signed(samp_code);
        m_temp = t;
        if (t > m_up) m_fhi = 1; else if (t < m_up - m_h) m_fhi = 0;
        if (t > m_cr) m_fcr = 1; else if (t < m_cr - m_h) m_fcr = 0;
        if (t < m_lo) m_flo = 1; else if (t > m_lo + m_h) m_flo = 0;
      end
      if (wr_en && !m_cfg[8]) begin
        case (wr_sel)
          2'd0: m_lo = $signed(wr_data);
          2'd1: m_up = $signed(wr_data);
          2'd2: m_cr = $signed(wr_data);
          default: m_cfg = {wr_data[8], 1'b0, wr_data[6:0]};
        endcase
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cmp(input int act, input int exp, input string tag);
    chk(act == exp, tag, act, exp);
  endtask

  // every-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      cmp($signed(temp_q), m_temp, "R2 temp_q");
      cmp(flag_hi, m_fhi, "R3 flag_hi");
      cmp(flag_lo, m_flo, "R4 flag_lo");
      cmp(flag_crit, m_fcr, "R5 flag_crit");
      cmp(evt_status, m_stat, m_cfg[5] ? "R8 evt_status" : "R7 evt_status");
      cmp(evt_pull, m_pull, "R11 evt_pull");
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog: actual %0d cycles expected completion", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  // ---------------- stimulus helpers ----------------
  function automatic logic [10:0] cw(input int hy, input bit en, input bit ah, input bit irq,
                                      input bit co, input bit cl, input bit lk);
    return {2'b00, lk, cl, co, irq, ah, en, 3'(hy)};
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int sel, input int v);
    @(negedge clk);
    wr_en = 1; wr_sel = 2'(sel); wr_data = 11'(v);
    @(negedge clk);
    wr_en = 0;
    idle(3);
  endtask

  task automatic samp(input int v);
    @(negedge clk);
    samp_vld = 1; samp_code = 11'(v);
    @(negedge clk);
    samp_vld = 0;
    idle(3);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1;
    idle(3);
    cmp(temp_q, 0, "R1 temp_q");
    cmp({flag_lo, flag_hi, flag_crit}, 0, "R1 flags");
    cmp(evt_status, 0, "R1 evt_status");
    cmp(evt_pull, 0, "R1 evt_pull");
    rst = 0;
  endtask

  initial begin
    do_reset();

    wr(0, 80); wr(1, 640); wr(2, 760); wr(3, cw(2, 1, 0, 0, 0, 0, 0));
    samp(400);
    cmp(flag_hi, 0, "R3 inside window"); cmp(evt_status, 0, "R7 quiet");
    samp(641);
    cmp(flag_hi, 1, "R13 upper select"); cmp(evt_status, 1, "R7 follows");
    cmp(evt_pull, 1, "R11 active-low pull");
    samp(630); cmp(flag_hi, 1, "R6 1.5C hold");
    samp(627); cmp(flag_hi, 0, "R3 release"); cmp(evt_status, 0, "R7 drops");

    wr(3, cw(3, 1, 0, 0, 0, 0, 0));
    samp(641); samp(617); cmp(flag_hi, 1, "R6 3C hold");
    samp(615); cmp(flag_hi, 0, "R6 3C release");
    wr(3, cw(4, 1, 0, 0, 0, 0, 0));
    samp(641); samp(593); cmp(flag_hi, 1, "R6 6C hold");
    samp(591); cmp(flag_hi, 0, "R6 6C release");
    wr(3, cw(1, 1, 0, 0, 0, 0, 0));
    samp(641); samp(639); cmp(flag_hi, 0, "R6 zero step");
    wr(3, cw(6, 1, 0, 0, 0, 0, 0));
    samp(641); samp(639); cmp(flag_hi, 0, "R6 unused code");

    wr(0, -80); wr(3, cw(2, 1, 0, 0, 0, 0, 0));
    samp(-81); cmp(flag_lo, 1, "R4 negative set");
    samp(-70); cmp(flag_lo, 1, "R4 hold");
    samp(-67); cmp(flag_lo, 0, "R4 release");

    samp(761); cmp(flag_crit, 1, "R5 set"); cmp(flag_hi, 1, "R3 set");
    samp(750); cmp(flag_crit, 1, "R5 hold");
    samp(700); cmp(flag_crit, 0, "R5 release"); cmp(flag_hi, 1, "R3 hold");

    wr(3, cw(2, 1, 0, 0, 1, 0, 0));
    cmp(evt_status, 0, "R10 upper ignored");
    samp(761); cmp(evt_status, 1, "R10 critical");
    samp(400); cmp(evt_status, 0, "R10 drop");

    wr(3, cw(2, 1, 0, 1, 0, 0, 0));
    samp(641); cmp(evt_status, 1, "R8 set");
    samp(400); cmp(evt_status, 1, "R8 latched");
    wr(3, cw(2, 1, 0, 1, 0, 1, 0)); cmp(evt_status, 0, "R8 cleared");
    samp(761); cmp(evt_status, 1, "R8 crit set");
    wr(3, cw(2, 1, 0, 1, 0, 1, 0)); cmp(evt_status, 1, "R9 crit not clearable");
    samp(400); cmp(evt_status, 1, "R8 still latched");
    wr(3, cw(2, 1, 0, 1, 0, 1, 0)); cmp(evt_status, 0, "R9 clear after crit");

    wr(3, cw(2, 1, 0, 0, 0, 0, 0));
    samp(641);
    wr(3, cw(2, 1, 0, 0, 0, 1, 0)); cmp(evt_status, 1, "R9 comparator clear");
    samp(400);

    wr(3, cw(2, 1, 1, 0, 0, 0, 0)); cmp(evt_pull, 1, "R11 active-high idle");
    samp(641); cmp(evt_pull, 0, "R11 active-high event");
    wr(3, cw(2, 0, 1, 0, 0, 0, 0)); cmp(evt_pull, 0, "R11 disabled");
    samp(400);

    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      samp_vld = 0; wr_en = 0;
      case ($urandom_range(0, 3))
        0: begin wr_en = 1; wr_sel = 2'($urandom_range(0, 3));
                 wr_data = 11'($urandom) & ((wr_sel == 2'd3) ? 11'h0FF : 11'h7FF); end
        1, 2: begin samp_vld = 1; samp_code = 11'($urandom); end
        default: ;
      endcase
    end
    @(negedge clk);
    samp_vld = 0; wr_en = 0;
    idle(3);

    do_reset();
    wr(1, 640); wr(2, 760); wr(0, -80);
    wr(3, cw(2, 1, 0, 1, 0, 0, 1));
    wr(1, 100);
    samp(200); cmp(flag_hi, 0, "R12 limit locked");
    wr(3, cw(4, 1, 1, 0, 0, 0, 0));
    samp(641); cmp(evt_status, 1, "R12 mode locked");
    cmp(evt_pull, 1, "R12 polarity locked");
    samp(400); cmp(evt_status, 1, "R12 still interrupt");
    wr(3, cw(2, 1, 0, 1, 0, 1, 1)); cmp(evt_status, 0, "R12 clear works");

    do_reset();
    wr(1, 100); wr(3, cw(0, 1, 0, 0, 0, 0, 0));
    samp(200); cmp(flag_hi, 1, "R1 lock released by reset");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule